// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block moves bytes between memory and one peripheral byte stream, in either direction, using two alternating buffer slots. Each slot holds a start address and a byte count. While one slot is being worked on, software fills the other, so the channel can go straight on to the next buffer with no gap. Software sets up the channel through a 32-bit register interface. The channel raises interrupts when it hands over from one slot to the other, when it runs out of loaded slots, and when memory returns an error.

The channel reports its state as one of four values. Idle means it is disabled or has never been started. Stall means it is enabled and both slots are spent. On means one slot is loaded. Next means both slots are loaded. To shut the channel down, software first clears the interrupt enables and lets the current slot run out. It then clears the channel enable, which brings the channel back to idle. Each byte makes one memory access with a request and acknowledge handshake, and one valid/ready handshake on the peripheral side. Control bit 2 selects the direction.

Top module: `dbdma_chan`

## Requirements
- R1: After reset, the status register (offset 0x0C), the interrupt register (0x04) and the control register (0x00) read 0, and `irq_o` and `mem_req_o` are low.
- R2: The control register reads back the last value written, with bits 0,1,2,3,4,6 kept and all other bits zero. The low 4 bits written to offset 0x08 drive `per_sel_o` and read back from that offset; the upper bits read as zero.
- R3: Slot 0 has its count at 0x20 and its base at 0x24. Slot 1 has its count at 0x30 and its base at 0x34. Writing a base register marks that slot loaded. If the channel is enabled (control bit 4) and in idle or stall, loading a slot starts that slot in the next cycle. The status register reads state in [5:4] (0 idle, 1 stall, 2 on, 3 next), the slot-loaded flags in [3:2] and the current slot in bit 0.
- R4: When control bit 2 is 1, byte i of a slot is read from memory at base+i and then offered on `per_tx_data_o`, in order. Exactly count bytes are sent.
- R5: When control bit 2 is 0, the bytes accepted from the peripheral are written to memory at base, base+1, and so on, in order of arrival.
- R6: While the current slot runs and the other slot is loaded, the state reads next (3). When the current slot finishes, the channel moves to the other slot and sets interrupt bit 1. Loading any slot clears bit 1.
- R7: When a slot finishes and the other slot is not loaded, the state becomes stall (1). Interrupt bit 0 reads 1 for as long as the state is stall.
- R8: `irq_o` is the OR of interrupt bits 0, 1 and 3, each masked by its enable in control bits 0, 1 and 3. The raw bits still read back when their enables are off.
- R9: A memory acknowledge that comes with `mem_err_i` sets interrupt bit 3, but only while control bit 6 is set. Any write to offset 0x04 clears bit 3.
- R10: Clearing the enable while in stall brings the state to idle one cycle after the write takes effect. Clearing it while a slot runs lets that slot finish, then goes to idle and drops the other slot without moving its data.
- R11: A slot loaded with count 0 completes without any memory access, and the channel stalls on that slot.
- R12: Writes to the count or base register of the slot the channel is working on (state on or next) are ignored.
- R13: A count register keeps only its low 16 bits, so a slot moves at most 0xFFFF bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | 1 for a memory write, 0 for a read |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_err_i | input | 1 | Memory error, qualified by mem_ack_i |
| per_sel_o | output | 4 | Selected peripheral port |
| per_tx_valid_o | output | 1 | Byte offered to the peripheral |
| per_tx_data_o | output | 8 | Byte to the peripheral |
| per_tx_ready_i | input | 1 | Peripheral accepts the byte |
| per_rx_valid_i | input | 1 | Peripheral offers a byte |
| per_rx_data_i | input | 8 | Byte from the peripheral |
| per_rx_ready_o | output | 1 | Channel accepts the byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench moves data out of memory through two slots loaded back to back. This tells a correct handoff between slots apart from a stall or a dropped slot, and the status readback separates on from next. It moves data into memory from a counting byte source, which shows ordering and address stepping in the write path. A zero-length slot checks completion with no memory access. A run with an error address shows error capture and clearing. Finally, the enable is cleared while one slot runs and the other is loaded: the bench must see the running slot's bytes arrive and none from the other slot.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STALL = 2'd1,
    ST_ON    = 2'd2,
    ST_NEXT  = 2'd3
  } ch_state_e;

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_INT   = 8'h04;
  localparam logic [7:0] A_PORT  = 8'h08;
  localparam logic [7:0] A_STAT  = 8'h0C;
  localparam logic [7:0] A_CNT0  = 8'h20;
  localparam logic [7:0] A_BASE0 = 8'h24;
  localparam logic [7:0] A_CNT1  = 8'h30;
  localparam logic [7:0] A_BASE1 = 8'h34;

  localparam int C_STALL_IE = 0;
  localparam int C_NFB_IE   = 1;
  localparam int C_DIR_TX   = 2;
  localparam int C_ERR_IE   = 3;
  localparam int C_EN       = 4;
  localparam int C_ERR_CAP  = 6;

  localparam logic [6:0] CTRL_MASK = 7'h5F;

endpackage

// File: rtl/dbdma_seq.sv
module dbdma_seq
  import dbdma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] ld_i,
  input  logic       done_i,
  output ch_state_e  state_o,
  output logic       cur_o,
  output logic [1:0] valid_o,
  output logic       busy_o,
  output logic       handoff_o
);

  ch_state_e  state_q, state_n;
  logic       cur_q, cur_n, pref_q, pref_n;
  logic [1:0] valid_q, valid_n;
  logic       busy;

  assign busy = (state_q == ST_ON) || (state_q == ST_NEXT);

  always_comb begin
    valid_n   = valid_q | ld_i;
    state_n   = state_q;
    cur_n     = cur_q;
    pref_n    = pref_q;
    handoff_o = 1'b0;
    if (busy && done_i) valid_n[cur_q] = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_STALL: begin
        if (!en_i) begin
          state_n = ST_IDLE;
        end else if (|valid_n) begin
          cur_n   = valid_n[pref_q] ? pref_q : ~pref_q;
          state_n = (&valid_n) ? ST_NEXT : ST_ON;
        end
      end
      default: begin
        if (done_i) begin
          pref_n = ~cur_q;
          if (!en_i) begin
            state_n = ST_IDLE;
            valid_n = '0;
          end else if (valid_n[~cur_q]) begin
            cur_n     = ~cur_q;
            state_n   = ST_ON;
            handoff_o = 1'b1;
          end else begin
            state_n = ST_STALL;
          end
        end else begin
          state_n = (&valid_n) ? ST_NEXT : ST_ON;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= 1'b0;
      pref_q  <= 1'b0;
      valid_q <= '0;
    end else begin
      state_q <= state_n;
      cur_q   <= cur_n;
      pref_q  <= pref_n;
      valid_q <= valid_n;
    end
  end

  assign state_o = state_q;
  assign cur_o   = cur_q;
  assign valid_o = valid_q;
  assign busy_o  = busy;

  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && en_i && valid_q == 2'b00 && ld_i == 2'b01) |=> (state_q == ST_ON && !cur_q));

  p_handoff_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && done_i && en_i && valid_q[~cur_q]) |=> (state_q == ST_ON && cur_q != $past(cur_q)));

  p_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && done_i && en_i && !valid_q[~cur_q] && !ld_i[~cur_q]) |=> (state_q == ST_STALL));

  p_shutdown_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STALL && !en_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/dbdma_mover.sv
module dbdma_mover #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          dir_tx_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  input  logic          mem_err_i,
  output logic          per_tx_valid_o,
  output logic [DW-1:0] per_tx_data_o,
  input  logic          per_tx_ready_i,
  input  logic          per_rx_valid_i,
  input  logic [DW-1:0] per_rx_data_i,
  output logic          per_rx_ready_o,
  output logic          done_o,
  output logic          err_o
);

  typedef enum logic [1:0] {M_CHK, M_MEM, M_PER} mv_state_e;

  mv_state_e     st_q;
  logic [CW-1:0] off_q;
  logic [DW-1:0] byte_q;

  assign done_o = (st_q == M_CHK) && run_i && (off_q == cnt_i);
  assign err_o  = (st_q == M_MEM) && mem_ack_i && mem_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= M_CHK;
      off_q  <= '0;
      byte_q <= '0;
    end else begin
      unique case (st_q)
        M_CHK: begin
          if (run_i) begin
            if (off_q == cnt_i) off_q <= '0;
            else st_q <= dir_tx_i ? M_MEM : M_PER;
          end
        end
        M_MEM: begin
          if (mem_ack_i) begin
            if (dir_tx_i) begin
              byte_q <= mem_rdata_i;
              st_q   <= M_PER;
            end else begin
              off_q <= off_q + 1'b1;
              st_q  <= M_CHK;
            end
          end
        end
        default: begin
          if (dir_tx_i) begin
            if (per_tx_ready_i) begin
              off_q <= off_q + 1'b1;
              st_q  <= M_CHK;
            end
          end else if (per_rx_valid_i) begin
            byte_q <= per_rx_data_i;
            st_q   <= M_MEM;
          end
        end
      endcase
    end
  end

  assign mem_req_o      = (st_q == M_MEM);
  assign mem_we_o       = !dir_tx_i;
  assign mem_addr_o     = base_i + AW'(off_q);
  assign mem_wdata_o    = byte_q;
  assign per_tx_valid_o = (st_q == M_PER) && dir_tx_i;
  assign per_tx_data_o  = byte_q;
  assign per_rx_ready_o = (st_q == M_PER) && !dir_tx_i;

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_tx_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_tx_valid_o && !per_tx_ready_i) |=> (per_tx_valid_o && $stable(per_tx_data_o)));

  p_off_bound_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (off_q <= cnt_i));

endmodule

// File: rtl/dbdma_irq.sv
module dbdma_irq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stall_lvl_i,
  input  logic       handoff_i,
  input  logic       nfb_clr_i,
  input  logic       err_i,
  input  logic       err_cap_i,
  input  logic       err_clr_i,
  input  logic       ie_stall_i,
  input  logic       ie_nfb_i,
  input  logic       ie_err_i,
  output logic [3:0] pend_o,
  output logic       irq_o
);

  logic nfb_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nfb_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (handoff_i)      nfb_q <= 1'b1;
      else if (nfb_clr_i) nfb_q <= 1'b0;
      if (err_clr_i)                  err_q <= 1'b0;
      else if (err_i && err_cap_i)    err_q <= 1'b1;
    end
  end

  assign pend_o = {err_q, 1'b0, nfb_q, stall_lvl_i};
  assign irq_o  = (stall_lvl_i && ie_stall_i) || (nfb_q && ie_nfb_i) || (err_q && ie_err_i);

  p_err_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && err_cap_i && !err_clr_i) |=> err_q);

  p_err_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i |=> !err_q);

  p_nfb_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handoff_i |=> nfb_q);

endmodule

// File: rtl/dbdma_chan.sv
module dbdma_chan
  import dbdma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CW     = 16,
  parameter int DW     = 8,
  parameter int PORT_W = 4,
  parameter int RAW    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RAW-1:0]    reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  output logic [PORT_W-1:0] per_sel_o,
  output logic              per_tx_valid_o,
  output logic [DW-1:0]     per_tx_data_o,
  input  logic              per_tx_ready_i,
  input  logic              per_rx_valid_i,
  input  logic [DW-1:0]     per_rx_data_i,
  output logic              per_rx_ready_o,
  output logic              irq_o
);

  localparam int NSLOT = 2;

  logic [6:0]          ctrl_q;
  logic [PORT_W-1:0]   port_q;
  logic [CW-1:0]       cnt_w  [NSLOT];
  logic [AW-1:0]       base_w [NSLOT];
  logic [NSLOT-1:0]    ld;
  ch_state_e           state;
  logic                cur, busy, handoff, done, err;
  logic [NSLOT-1:0]    valid;
  logic [3:0]          pend;

  logic wr_ctrl, wr_port, wr_int;
  assign wr_ctrl = reg_we_i && (reg_addr_i == RAW'(A_CTRL));
  assign wr_port = reg_we_i && (reg_addr_i == RAW'(A_PORT));
  assign wr_int  = reg_we_i && (reg_addr_i == RAW'(A_INT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      port_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata_i[6:0] & CTRL_MASK;
      if (wr_port) port_q <= reg_wdata_i[PORT_W-1:0];
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [RAW-1:0] CA = (s == 0) ? RAW'(A_CNT0)  : RAW'(A_CNT1);
    localparam logic [RAW-1:0] BA = (s == 0) ? RAW'(A_BASE0) : RAW'(A_BASE1);
    logic          lock, wr_c, wr_b;
    logic [CW-1:0] c_q;
    logic [AW-1:0] b_q;

    assign lock  = busy && (cur == 1'(s));
    assign wr_c  = reg_we_i && (reg_addr_i == CA) && !lock;
    assign wr_b  = reg_we_i && (reg_addr_i == BA) && !lock;
    assign ld[s] = wr_b;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        c_q <= '0;
        b_q <= '0;
      end else begin
        if (wr_c) c_q <= reg_wdata_i[CW-1:0];
        if (wr_b) b_q <= reg_wdata_i[AW-1:0];
      end
    end

    assign cnt_w[s]  = c_q;
    assign base_w[s] = b_q;

    p_lock_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy && cur == 1'(s) && reg_we_i && (reg_addr_i == CA || reg_addr_i == BA))
      |=> ($stable(c_q) && $stable(b_q)));
  end

  dbdma_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (ctrl_q[C_EN]),
    .ld_i      (ld),
    .done_i    (done),
    .state_o   (state),
    .cur_o     (cur),
    .valid_o   (valid),
    .busy_o    (busy),
    .handoff_o (handoff)
  );

  dbdma_mover #(.AW(AW), .CW(CW), .DW(DW)) u_mover (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .run_i          (busy),
    .dir_tx_i       (ctrl_q[C_DIR_TX]),
    .base_i         (base_w[cur]),
    .cnt_i          (cnt_w[cur]),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .mem_wdata_o    (mem_wdata_o),
    .mem_rdata_i    (mem_rdata_i),
    .mem_ack_i      (mem_ack_i),
    .mem_err_i      (mem_err_i),
    .per_tx_valid_o (per_tx_valid_o),
    .per_tx_data_o  (per_tx_data_o),
    .per_tx_ready_i (per_tx_ready_i),
    .per_rx_valid_i (per_rx_valid_i),
    .per_rx_data_i  (per_rx_data_i),
    .per_rx_ready_o (per_rx_ready_o),
    .done_o         (done),
    .err_o          (err)
  );

  dbdma_irq u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stall_lvl_i (state == ST_STALL),
    .handoff_i   (handoff),
    .nfb_clr_i   (|ld),
    .err_i       (err),
    .err_cap_i   (ctrl_q[C_ERR_CAP]),
    .err_clr_i   (wr_int),
    .ie_stall_i  (ctrl_q[C_STALL_IE]),
    .ie_nfb_i    (ctrl_q[C_NFB_IE]),
    .ie_err_i    (ctrl_q[C_ERR_IE]),
    .pend_o      (pend),
    .irq_o       (irq_o)
  );

  assign per_sel_o = port_q;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == RAW'(A_CTRL))       reg_rdata_o = 32'(ctrl_q);
    else if (reg_addr_i == RAW'(A_INT))   reg_rdata_o = 32'(pend);
    else if (reg_addr_i == RAW'(A_PORT))  reg_rdata_o = 32'(port_q);
    else if (reg_addr_i == RAW'(A_STAT))  reg_rdata_o = 32'({state, valid, 1'b0, cur});
    else if (reg_addr_i == RAW'(A_CNT0))  reg_rdata_o = 32'(cnt_w[0]);
    else if (reg_addr_i == RAW'(A_BASE0)) reg_rdata_o = 32'(base_w[0]);
    else if (reg_addr_i == RAW'(A_CNT1))  reg_rdata_o = 32'(cnt_w[1]);
    else if (reg_addr_i == RAW'(A_BASE1)) reg_rdata_o = 32'(base_w[1]);
  end

  p_quiet_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> (!mem_req_o && !per_tx_valid_o && !per_rx_ready_o));

  p_port_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_port |=> (per_sel_o == $past(reg_wdata_i[PORT_W-1:0])));

  p_access_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy);

endmodule

// File: tb/dbdma_chan_tb.sv
module dbdma_chan_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic [3:0]  per_sel;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic        rx_valid = 1'b1;
  logic [7:0]  rx_data = 8'hC0;
  logic        rx_ready;
  logic        irq;

  always #10 clk = ~clk;

  dbdma_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .mem_err_i(mem_err),
    .per_sel_o(per_sel),
    .per_tx_valid_o(tx_valid), .per_tx_data_o(tx_data), .per_tx_ready_i(tx_ready),
    .per_rx_valid_i(rx_valid), .per_rx_data_i(rx_data), .per_rx_ready_o(rx_ready),
    .irq_o(irq)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  int          mem_hits = 0;
  logic [7:0]  tx_q[$];
  logic [39:0] wr_q[$];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [7:0]  exp_rx = 8'hC0;
  logic        rx_hs_pend = 1'b0;

  function automatic logic [7:0] mem_f(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // monitor: memory model, rx source, scoreboard pops
  always @(negedge clk) begin
    if (rx_hs_pend) rx_data = rx_data + 8'd1;
    rx_hs_pend = rx_ready && rx_valid;
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      mem_hits++;
      mem_ack   = 1'b1;
      mem_rdata = mem_f(mem_addr);
      mem_err   = (mem_addr == err_addr);
      if (mem_we) begin
        if (wr_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R5 unexpected write got=%h_%h exp=none", mem_addr, mem_wdata);
        end else begin
          logic [39:0] e;
          e = wr_q.pop_front();
          check("R5 memory write", {mem_addr, mem_wdata}, e[39:8] == mem_addr ? {e[39:8], e[7:0]} : {e[39:8], e[7:0]});
        end
      end
    end
    if (tx_valid && tx_ready) begin
      if (tx_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R4 unexpected tx byte got=%h exp=none", tx_data);
      end else begin
        check("R4 tx byte", 32'(tx_data), 32'(tx_q.pop_front()));
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic load_tx(input bit s, input logic [31:0] base, input int cnt);
    for (int i = 0; i < cnt; i++) tx_q.push_back(mem_f(base + 32'(i)));
    wr(s ? 6'h30 : 6'h20, 32'(cnt));
    wr(s ? 6'h34 : 6'h24, base);
  endtask

  task automatic load_rx(input bit s, input logic [31:0] base, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      wr_q.push_back({base + 32'(i), exp_rx});
      exp_rx = exp_rx + 8'd1;
    end
    wr(s ? 6'h30 : 6'h20, 32'(cnt));
    wr(s ? 6'h34 : 6'h24, base);
  endtask

  task automatic wait_st(input logic [1:0] st, input string tag);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd(6'h0C, v);
      if (v[5:4] == st) break;
    end
    check(tag, 32'(v[5:4]), 32'(st));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int          hits0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h0C, v); check("R1 status", v, 32'h0);
    rd(6'h04, v); check("R1 int", v, 32'h0);
    rd(6'h00, v); check("R1 ctrl", v, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 mem_req", 32'(mem_req), 32'h0);

    // R2 readback, R13 count width
    wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, v); check("R2 ctrl readback", v, 32'h5F);
    wr(6'h00, 32'h0);
    wr(6'h08, 32'h1234_56A7); rd(6'h08, v); check("R2 port readback", v, 32'h7);
    check("R2 per_sel_o", 32'(per_sel), 32'h7);
    wr(6'h30, 32'h0001_0002); rd(6'h30, v); check("R13 count width", v, 32'h2);

    // R3 R4 R6 R12: transmit through both slots
    wr(6'h00, 32'h17);
    load_tx(1'b0, 32'h100, 8);
    rd(6'h0C, v); check("R3 started slot0 on", v, 32'h24);
    wr(6'h20, 32'h55);
    rd(6'h20, v); check("R12 active count write ignored", v, 32'h8);
    load_tx(1'b1, 32'h200, 3);
    rd(6'h0C, v); check("R6 both loaded reads next", v, 32'h3C);
    wait_st(2'd1, "R7 stall after slots");
    rd(6'h04, v); check("R6 R7 int bits", v, 32'h3);
    check("R7 irq with enables", 32'(irq), 32'h1);
    rd(6'h0C, v); check("R6 ended on slot1", 32'(v[0]), 32'h1);
    check("R4 tx queue drained", 32'(tx_q.size()), 32'h0);

    // R8 masking
    wr(6'h00, 32'h14); check("R8 irq masked", 32'(irq), 32'h0);
    rd(6'h04, v); check("R8 raw bits kept", v, 32'h3);
    wr(6'h00, 32'h15); check("R8 stall enable", 32'(irq), 32'h1);

    // R10 shutdown from stall
    wr(6'h00, 32'h04);
    @(negedge clk);
    rd(6'h0C, v); check("R10 stall to idle", 32'(v[5:4]), 32'h0);

    // R5 receive
    wr(6'h00, 32'h11);
    load_rx(1'b0, 32'h400, 3);
    wait_st(2'd1, "R5 rx stall");
    check("R5 write queue drained", 32'(wr_q.size()), 32'h0);

    // R11 zero-count slot
    hits0 = mem_hits;
    wr(6'h30, 32'h0);
    wr(6'h34, 32'h500);
    repeat (5) @(negedge clk);
    rd(6'h0C, v); check("R11 zero count stalls on slot1", {v[5:4], v[0]}, {2'd1, 1'b1});
    check("R11 no memory access", 32'(mem_hits), 32'(hits0));

    // R9 error capture and clear
    wr(6'h00, 32'h59);
    err_addr = 32'h601;
    load_rx(1'b0, 32'h600, 2);
    wait_st(2'd1, "R9 rx stall");
    rd(6'h04, v); check("R9 error captured", v, 32'h9);
    wr(6'h00, 32'h58); check("R9 irq from error", 32'(irq), 32'h1);
    wr(6'h04, 32'h0);
    rd(6'h04, v); check("R9 error cleared", v, 32'h1);
    check("R9 irq after clear", 32'(irq), 32'h0);
    err_addr = 32'hFFFF_FFFF;

    // R10 enable dropped while running: slot0 finishes, slot1 dropped
    wr(6'h00, 32'h14);
    load_tx(1'b0, 32'h700, 6);
    wr(6'h30, 32'h2);
    wr(6'h34, 32'h800);
    wr(6'h00, 32'h04);
    wait_st(2'd0, "R10 idle after drain");
    repeat (20) @(negedge clk);
    rd(6'h0C, v); check("R10 stays idle, other slot dropped", v[5:2], 4'h0);
    check("R10 running slot finished", 32'(tx_q.size()), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule